// File: doc/BRIEF.md
# Hash Engine Register Front-End and Block Request Logic

This block is the register front-end of a hash accelerator. It sits on an APB-style bus and holds a control/status word, a write-only data port and eight read-only digest words. Data words written to the data port go straight to an external hash core; there is no FIFO. A block therefore always has a fixed size in bytes, and the block counts transfers until that block is full. It then drops its write-ready status until the core reports that the block digest is finished.

A DMA request line tells a DMA engine that it may send the whole remaining block. The number of transfers per block depends on a programmable transfer-size field: with 64-byte blocks this is 64 byte transfers, 32 halfword transfers or 16 word transfers. Software starts a new hash by writing the start bit. Software (or DMA) then feeds padded blocks, and reads the digest once the valid flag is high. A write that lands while the core is busy is dropped and latched in a sticky error flag. Software clears that flag by writing a one to it.

Top module: `hash_ctl`

## Requirements
- R1: After reset the control word at word index 0 reads 0x1206: bit 12 byte-swap enable = 1, bits 9:8 transfer size = 2, bit 2 digest-valid = 1, bit 1 write-ready = 1, bit 4 write-error = 0, bit 0 start = 0.
- R2: Writing the control word with bit 0 set makes write-ready and digest-valid read 1 from the next cycle on and clears the transfer count. Bit 0 always reads 0.
- R3: A block is full after BLOCK_BYTES >> size accepted data writes: 64 for size 0 (8-bit), 32 for size 1 (16-bit), and 16 for size 2 (32-bit) or size 3. Write-ready drops in the cycle after the last accepted write.
- R4: `dma_req` is high while write-ready is high and the block still lacks transfers. It goes low in the cycle after the last transfer of the block is accepted.
- R5: A data write (word index 1) while write-ready is low produces no `core_wr` pulse, does not advance the transfer count, and sets write-error.
- R6: Writing the control word with bit 4 set clears write-error. Writing it with bit 4 clear leaves write-error unchanged.
- R7: Digest-valid goes low on the first accepted data write of a block and returns high when `core_done` pulses.
- R8: A `core_done` pulse makes write-ready and `dma_req` high again for the next block.
- R9: Word index 2+i (i = 0..7) reads digest bits [255-32i : 224-32i]. Word index 2 therefore holds the most significant word.
- R10: Writes to control bits 1 and 2 have no effect. The data port reads 0. Word indices 10 to 15 read 0.
- R11: Each accepted data write gives a one-cycle `core_wr` pulse carrying `pwdata` unchanged, together with the current transfer size and byte-swap enable.
- R12: Transfer size (bits 9:8) and byte-swap enable (bit 12) take the written value and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 4 | Word index (byte offset divided by four) |
| pwdata | input | 32 | Bus write data |
| prdata | output | 32 | Bus read data |
| dma_req | output | 1 | Request for the remaining transfers of the current block |
| core_wr | output | 1 | One-cycle strobe of an accepted data transfer |
| core_wdata | output | 32 | Transfer data forwarded to the packer and core |
| core_size | output | 2 | Current transfer-size code |
| core_bswap | output | 1 | Current byte-swap enable |
| core_done | input | 1 | Pulse from the core when a block digest has finished |
| core_digest | input | 256 | Current digest from the core |

## Verification
The core can report that a block is finished in the same cycle in which a data write arrives while the block is still busy. The bench provokes this case by raising `core_done` during the access phase of that write. The write must be judged against the ready state before the edge: no `core_wr` pulse, write-error set, and ready high afterwards. The bench then sends a full block and checks that ready drops exactly after its last transfer, which shows that the rejected write did not advance the count. Every transfer size is swept with an arithmetic block length.

// File: rtl/hash_ctl_pkg.sv
package hash_ctl_pkg;
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_DATA = 1;
  localparam int unsigned IDX_DIG0 = 2;

  localparam int unsigned BIT_GO    = 0;
  localparam int unsigned BIT_RDY   = 1;
  localparam int unsigned BIT_VLD   = 2;
  localparam int unsigned BIT_ERR   = 4;
  localparam int unsigned BIT_SZ_LO = 8;
  localparam int unsigned BIT_SWAP  = 12;

  typedef enum logic [1:0] {
    XFER_B8  = 2'd0,
    XFER_B16 = 2'd1,
    XFER_B32 = 2'd2,
    XFER_RSV = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/hash_ctl_csr.sv
module hash_ctl_csr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       wd_go,
  input  logic       wd_err,
  input  logic [1:0] wd_size,
  input  logic       wd_swap,
  input  logic       data_wr,
  input  logic       rdy,
  output logic       go_pulse,
  output logic       err,
  output logic [1:0] size,
  output logic       swap
);
  import hash_ctl_pkg::*;

  logic       err_q, err_d;
  logic [1:0] size_q, size_d;
  logic       swap_q, swap_d;

  assign go_pulse = ctrl_wr & wd_go;

  always_comb begin
    err_d  = err_q;
    size_d = size_q;
    swap_d = swap_q;
    if (data_wr && !rdy)
      err_d = 1'b1;
    else if (ctrl_wr && wd_err)
      err_d = 1'b0;
    if (ctrl_wr) begin
      size_d = wd_size;
      swap_d = wd_swap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      size_q <= XFER_B32;
      swap_q <= 1'b1;
    end else begin
      err_q  <= err_d;
      size_q <= size_d;
      swap_q <= swap_d;
    end
  end

  assign err  = err_q;
  assign size = size_q;
  assign swap = swap_q;

  AST_BUSY_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !rdy) |=> err_q) else $error("busy write not flagged"); // R5
  AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wd_err && !data_wr) |=> !err_q) else $error("error not cleared"); // R6
endmodule

// File: rtl/hash_ctl_blk.sv
module hash_ctl_blk #(
  parameter int unsigned BLOCK_BYTES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_wr,
  input  logic       go_pulse,
  input  logic       core_done,
  input  logic [1:0] size,
  output logic       rdy,
  output logic       vld,
  output logic       dreq,
  output logic       accept
);
  localparam int unsigned CNT_W = $clog2(BLOCK_BYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit, cnt_inc;
  logic             rdy_q, rdy_d, vld_q, vld_d;

  assign limit   = CNT_W'(BLOCK_BYTES >> ((size == 2'd3) ? 2'd2 : size));
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign accept  = data_wr & rdy_q;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    vld_d = vld_q;
    if (go_pulse) begin
      cnt_d = '0;
      rdy_d = 1'b1;
      vld_d = 1'b1;
    end else begin
      if (accept) begin
        vld_d = 1'b0;
        if (cnt_inc >= limit) begin
          cnt_d = '0;
          rdy_d = 1'b0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      if (core_done) begin
        rdy_d = 1'b1;
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b1;
      vld_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
      vld_q <= vld_d;
    end
  end

  assign rdy  = rdy_q;
  assign vld  = vld_q;
  assign dreq = rdy_q & (cnt_q < limit);

  AST_GO_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse |=> (rdy_q && vld_q)) else $error("start did not set ready"); // R2
  AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> rdy_q) else $error("done did not set ready"); // R8
  AST_WRITE_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !go_pulse && !core_done) |=> !vld_q) else $error("valid kept"); // R7
endmodule

// File: rtl/hash_ctl_rdmux.sv
module hash_ctl_rdmux #(
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DIG_WORDS = 8
) (
  input  logic [IDX_W-1:0]            idx,
  input  logic [DATA_W-1:0]           ctrl_word,
  input  logic [DIG_WORDS*DATA_W-1:0] digest,
  output logic [DATA_W-1:0]           rdata
);
  import hash_ctl_pkg::*;

  always_comb begin
    rdata = '0;
    if (idx == IDX_W'(IDX_CTRL))
      rdata = ctrl_word;
    for (int i = 0; i < DIG_WORDS; i++) begin
      if (idx == IDX_W'(IDX_DIG0 + i))
        rdata = digest[(DIG_WORDS-1-i)*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/hash_ctl.sv
module hash_ctl #(
  parameter int unsigned BLOCK_BYTES = 64,
  parameter int unsigned DIG_WORDS   = 8,
  parameter int unsigned IDX_W       = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [IDX_W-1:0]        paddr,
  input  logic [31:0]             pwdata,
  output logic [31:0]             prdata,
  output logic                    dma_req,
  output logic                    core_wr,
  output logic [31:0]             core_wdata,
  output logic [1:0]              core_size,
  output logic                    core_bswap,
  input  logic                    core_done,
  input  logic [DIG_WORDS*32-1:0] core_digest
);
  import hash_ctl_pkg::*;

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        wr_acc, ctrl_wr, data_wr;
  logic        go_pulse, err, swap, rdy, vld;
  logic [1:0]  size;
  logic [31:0] ctrl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_acc  = psel & penable & pwrite;
  assign ctrl_wr = wr_acc & (paddr == IDX_W'(IDX_CTRL));
  assign data_wr = wr_acc & (paddr == IDX_W'(IDX_DATA));

  hash_ctl_csr u_csr (
    .clk(clk), .rst_n(rst_int_n),
    .ctrl_wr(ctrl_wr),
    .wd_go(pwdata[BIT_GO]), .wd_err(pwdata[BIT_ERR]),
    .wd_size(pwdata[BIT_SZ_LO+1:BIT_SZ_LO]), .wd_swap(pwdata[BIT_SWAP]),
    .data_wr(data_wr), .rdy(rdy),
    .go_pulse(go_pulse), .err(err), .size(size), .swap(swap)
  );

  hash_ctl_blk #(.BLOCK_BYTES(BLOCK_BYTES)) u_blk (
    .clk(clk), .rst_n(rst_int_n),
    .data_wr(data_wr), .go_pulse(go_pulse), .core_done(core_done),
    .size(size), .rdy(rdy), .vld(vld), .dreq(dma_req), .accept(core_wr)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_RDY] = rdy;
    ctrl_word[BIT_VLD] = vld;
    ctrl_word[BIT_ERR] = err;
    ctrl_word[BIT_SZ_LO+1:BIT_SZ_LO] = size;
    ctrl_word[BIT_SWAP] = swap;
  end

  hash_ctl_rdmux #(.IDX_W(IDX_W), .DATA_W(32), .DIG_WORDS(DIG_WORDS)) u_rd (
    .idx(paddr), .ctrl_word(ctrl_word), .digest(core_digest), .rdata(prdata)
  );

  assign core_wdata = pwdata;
  assign core_size  = size;
  assign core_bswap = swap;

  AST_REQ_DROPS_AFTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!dma_req && !go_pulse && !core_done) |=> !dma_req) else $error("request rose alone"); // R4
endmodule

// File: tb/hash_ctl_tb_top.sv
module hash_ctl_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]   paddr = '0;
  logic [31:0]  pwdata = '0;
  logic [31:0]  prdata;
  logic         dma_req, core_wr, core_bswap;
  logic [31:0]  core_wdata;
  logic [1:0]   core_size;
  logic         core_done = 1'b0;
  logic [255:0] core_digest;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic        obs_wr;
  logic [31:0] obs_wd;
  logic [1:0]  obs_sz;
  logic        obs_sw;

  always #10 clk = ~clk;

  hash_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .dma_req(dma_req),
    .core_wr(core_wr), .core_wdata(core_wdata), .core_size(core_size),
    .core_bswap(core_bswap), .core_done(core_done), .core_digest(core_digest)
  );

  function automatic logic [31:0] dig_word(int i);
    return 32'hA5000000 + 32'h01030507 * (i + 1);
  endfunction

  always_comb
    for (int i = 0; i < 8; i++) core_digest[(7-i)*32 +: 32] = dig_word(i);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [3:0] a, input logic [31:0] d, input bit done);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1; core_done = done;
    #1;
    obs_wr = core_wr; obs_wd = core_wdata; obs_sz = core_size; obs_sw = core_bswap;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; core_done = 0;
  endtask

  task automatic apb_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); core_done = 1;
    @(negedge clk); core_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, cfg;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    apb_rd(4'd0, rd);
    chk("R1 reset control word", rd, 32'h0000_1206);
    chk("R4 request after reset", {31'b0, dma_req}, 32'd1);

    for (int sz = 0; sz < 4; sz++) begin
      int lim;
      logic b;
      lim = 64 >> ((sz == 3) ? 2 : sz);
      b = sz[0];
      cfg = (32'(b) << 12) | (32'(sz) << 8);
      apb_wr(4'd0, cfg | 32'h1, 0);
      apb_rd(4'd0, rd);
      chk("R2 R12 control after start", rd, cfg | 32'h6);
      for (int k = 0; k < lim; k++) begin
        apb_wr(4'd1, 32'h1000_0000 * sz + k * 32'h0001_0003, 0);
        chk("R11 strobe", {31'b0, obs_wr}, 32'd1);
        chk("R11 data", obs_wd, 32'h1000_0000 * sz + k * 32'h0001_0003);
        chk("R11 size and swap", {29'b0, obs_sz, obs_sw}, {29'b0, 2'(sz), b});
        chk("R3 R4 request", {31'b0, dma_req}, (k == lim - 1) ? 32'd0 : 32'd1);
        if (k == 0) begin
          apb_rd(4'd0, rd);
          chk("R7 valid low after first write", rd, cfg | 32'h2);
        end
      end
      apb_rd(4'd0, rd);
      chk("R3 block full", rd, cfg);
      apb_wr(4'd0, cfg | 32'h6, 0);
      apb_rd(4'd0, rd);
      chk("R10 read-only bits ignored", rd, cfg);
      apb_wr(4'd1, 32'hDEAD_BEEF, 0);
      chk("R5 no strobe while busy", {31'b0, obs_wr}, 32'd0);
      apb_rd(4'd0, rd);
      chk("R5 error set", rd, cfg | 32'h10);
      apb_wr(4'd0, cfg, 0);
      apb_rd(4'd0, rd);
      chk("R6 error kept on zero", rd, cfg | 32'h10);
      apb_wr(4'd0, cfg | 32'h10, 0);
      apb_rd(4'd0, rd);
      chk("R6 error cleared", rd, cfg);
      pulse_done();
      chk("R8 request after done", {31'b0, dma_req}, 32'd1);
      apb_rd(4'd0, rd);
      chk("R7 R8 ready and valid after done", rd, cfg | 32'h6);
    end

    for (int i = 0; i < 8; i++) begin
      apb_rd(4'(2 + i), rd);
      chk("R9 digest word", rd, dig_word(i));
    end
    apb_rd(4'd1, rd);
    chk("R10 data port reads zero", rd, 32'd0);
    for (int a = 10; a < 16; a++) begin
      apb_rd(4'(a), rd);
      chk("R10 unmapped reads zero", rd, 32'd0);
    end

    cfg = 32'h0000_0200;
    apb_wr(4'd0, cfg | 32'h1, 0);
    for (int k = 0; k < 16; k++) apb_wr(4'd1, 32'(k), 0);
    chk("R3 busy before collision", {31'b0, dma_req}, 32'd0);
    apb_wr(4'd1, 32'h5555_AAAA, 1);
    chk("R5 collision no strobe", {31'b0, obs_wr}, 32'd0);
    apb_rd(4'd0, rd);
    chk("R5 R8 collision error and ready", rd, cfg | 32'h16);
    for (int k = 0; k < 16; k++) begin
      apb_wr(4'd1, 32'(k), 0);
      chk("R3 R5 count not advanced", {31'b0, dma_req}, (k == 15) ? 32'd0 : 32'd1);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule